// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block takes one PWM command for a synchronous buck half-bridge and turns it into two gate enables, one for the high-side switch and one for the low-side switch. The two enables are never on together. The gap between them adapts to the bridge. Before the high side may turn on, the block waits until a comparator reports that the low-side gate has dropped. Before the low side may turn on, it waits until the switch node has fallen. In both cases a fixed settle count follows the comparator report. A second route to low-side turn-on exists for the case where the switch node never falls, for example when the converter sinks current. That route starts a long timer once the high-side gate is reported discharged.

The PWM command arrives already sorted into low, high or mid level by external comparators. A mid-level command turns both switches off. An active-low disable turns both switches off. An active-low skip input keeps the low side off while the high side still follows PWM. All seven input bits pass through two-flop synchronizers. Every delay is a parameter counted in clock cycles; the intended clock is 200 MHz.

Top module: `gate_sequencer`

## Requirements
- R1: `gateHi` is high only if `pwmCmd` was 2'b01 (high) three clock cycles earlier.
- R2: `gateLo` is high only if `pwmCmd` was 2'b00 (low) three cycles earlier. With skip inactive and the low path satisfied, `gateLo` turns on for a low command.
- R3: A mid-level command (2'b10 or 2'b11) forces both outputs low no later than the third rising clock edge after it is applied.
- R4: When `outEnN` is low, both outputs are low from the third edge onward, whatever `pwmCmd` is. After `outEnN` returns high, the normal sequence restarts.
- R5: When `skipN` is low, `gateLo` is low from the third edge onward, while `gateHi` still follows a high command with its normal timing.
- R6: After a change to the high command, `gateHi` waits for the synchronized low-side-gate-low flag and then `DT_HI_CYC` further cycles. With the flag already high, `gateHi` rises on edge 5+`DT_HI_CYC` (10 by default). With the flag held low, `gateHi` never rises.
- R7: After a change to the low command, `gateLo` waits for the synchronized switch-node-low flag and then `DT_LO_CYC` cycles. With the flag already high, `gateLo` rises on edge 5+`DT_LO_CYC` (9 by default).
- R8: If the switch-node flag stays low but the high-side-discharged flag is high, `gateLo` rises on edge 4+`TMO_CYC` (54 by default).
- R9: `gateHi` and `gateLo` are never high in the same cycle.
- R10: A PWM reversal while a turn-on is pending cancels that turn-on, and the sequence for the new level runs from its start.
- R11: During reset both outputs are low, and they stay low afterwards until a valid high or low command has been sequenced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmCmd | input | 2 | Decoded PWM level: 00 low, 01 high, 1x mid |
| outEnN | input | 1 | Active-low output disable (low forces both off) |
| skipN | input | 1 | Active-low skip mode (low keeps low side off) |
| lsGateLow | input | 1 | Comparator: low-side gate below threshold |
| swNodeLow | input | 1 | Comparator: switch node below threshold |
| hsDischarged | input | 1 | Comparator: high-side gate-source discharged |
| gateHi | output | 1 | High-side gate enable |
| gateLo | output | 1 | Low-side gate enable |

## Verification
Each scenario measures the exact edge on which an output turns on. This separates three cases: the sensed low-side-gate path, the sensed switch-node path, and the timeout path, which takes about fifty cycles longer. With the low-side-gate flag held low, the bench confirms that high-side turn-on waits on that flag and does not run on a plain counter. A reversal during that wait shows that the pending turn-on is cancelled. Disable, skip and mid-level commands are applied while an output is on, to measure the override latency. A disabled period that spans a PWM change shows that the sequence restarts once the disable is removed.

// File: rtl/gseq_pkg.sv
package gseq_pkg;
  typedef enum logic [1:0] {
    PWM_LO   = 2'b00,
    PWM_HI   = 2'b01,
    PWM_MID  = 2'b10,
    PWM_MIDX = 2'b11
  } pwmLvl_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_TO_HI,
    ST_DT_HI,
    ST_ON_HI,
    ST_TO_LO,
    ST_DT_LO,
    ST_ON_LO
  } seqState_e;

  typedef struct packed {
    logic dtRun;
    logic dtSelHi;
    logic tmoRun;
    logic allowHi;
    logic allowLo;
  } seqStrobe_t;
endpackage

// File: rtl/gseq_sync.sv
module gseq_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stable;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta   <= RST_VAL[i];
        stable <= RST_VAL[i];
      end else begin
        meta   <= din[i];
        stable <= meta;
      end
    end
    assign dout[i] = stable;
  end
endmodule

// File: rtl/gseq_ctrl.sv
module gseq_ctrl
  import gseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pwmS,
  input  logic       enS,
  input  logic       lsLowS,
  input  logic       swLowS,
  input  logic       dtDone,
  input  logic       tmoDone,
  output seqStrobe_t strobe
);
  seqState_e state, nextState;
  logic abort, wantHi, wantLo;

  assign abort  = !enS || pwmS[1];
  assign wantHi = (pwmS == PWM_HI);
  assign wantLo = (pwmS == PWM_LO);

  always_comb begin
    nextState = state;
    if (abort) begin
      nextState = ST_OFF;
    end else begin
      case (state)
        ST_OFF:   nextState = wantHi ? ST_TO_HI : ST_TO_LO;
        ST_TO_HI: if (wantLo) nextState = ST_TO_LO;
                  else if (lsLowS) nextState = ST_DT_HI;
        ST_DT_HI: if (wantLo) nextState = ST_TO_LO;
                  else if (dtDone) nextState = ST_ON_HI;
        ST_ON_HI: if (wantLo) nextState = ST_TO_LO;
        ST_TO_LO: if (wantHi) nextState = ST_TO_HI;
                  else if (tmoDone) nextState = ST_ON_LO;
                  else if (swLowS) nextState = ST_DT_LO;
        ST_DT_LO: if (wantHi) nextState = ST_TO_HI;
                  else if (dtDone || tmoDone) nextState = ST_ON_LO;
        ST_ON_LO: if (wantHi) nextState = ST_TO_HI;
        default:  nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  always_comb begin
    strobe.dtRun   = (state == ST_DT_HI) || (state == ST_DT_LO);
    strobe.dtSelHi = (state == ST_DT_HI);
    strobe.tmoRun  = (state == ST_TO_LO) || (state == ST_DT_LO);
    strobe.allowHi = (state == ST_ON_HI);
    strobe.allowLo = (state == ST_ON_LO);
  end
endmodule

// File: rtl/gseq_dp.sv
module gseq_dp
  import gseq_pkg::*;
#(
  parameter int DT_HI_CYC = 5,
  parameter int DT_LO_CYC = 4,
  parameter int TMO_CYC   = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic [1:0] pwmS,
  input  logic       enS,
  input  logic       skipS,
  input  logic       hsDisS,
  output logic       dtDone,
  output logic       tmoDone,
  output logic       gateHi,
  output logic       gateLo
);
  localparam int DT_MAX = (DT_HI_CYC > DT_LO_CYC) ? DT_HI_CYC : DT_LO_CYC;
  localparam int DW = $clog2(DT_MAX + 1);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [DW-1:0] DT_HI_END = DW'(DT_HI_CYC - 1);
  localparam logic [DW-1:0] DT_LO_END = DW'(DT_LO_CYC - 1);
  localparam logic [TW-1:0] TMO_END   = TW'(TMO_CYC - 1);

  logic [DW-1:0] dtCnt;
  logic [TW-1:0] tmoCnt;
  logic          tmoArmed, tmoCount;

  assign dtDone   = strobe.dtRun && (dtCnt == (strobe.dtSelHi ? DT_HI_END : DT_LO_END));
  assign tmoDone  = strobe.tmoRun && (tmoCnt == TMO_END);
  assign tmoCount = strobe.tmoRun && (tmoArmed || hsDisS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dtCnt <= '0;
    else if (!strobe.dtRun)   dtCnt <= '0;
    else if (!dtDone)         dtCnt <= dtCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoCnt   <= '0;
      tmoArmed <= 1'b0;
    end else if (!strobe.tmoRun) begin
      tmoCnt   <= '0;
      tmoArmed <= 1'b0;
    end else begin
      tmoArmed <= tmoCount;
      if (tmoCount && !tmoDone) tmoCnt <= tmoCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateHi <= 1'b0;
      gateLo <= 1'b0;
    end else begin
      gateHi <= strobe.allowHi && enS && (pwmS == PWM_HI);
      gateLo <= strobe.allowLo && enS && skipS && (pwmS == PWM_LO);
    end
  end
endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer
  import gseq_pkg::*;
#(
  parameter int DT_HI_CYC = 5,
  parameter int DT_LO_CYC = 4,
  parameter int TMO_CYC   = 50
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pwmCmd,
  input  logic       outEnN,
  input  logic       skipN,
  input  logic       lsGateLow,
  input  logic       swNodeLow,
  input  logic       hsDischarged,
  output logic       gateHi,
  output logic       gateLo
);
  localparam int SW = 7;
  localparam logic [SW-1:0] SYNC_RST = {PWM_MID, 1'b0, 1'b0, 3'b000};

  logic [SW-1:0] rawIn, syncIn;
  logic [1:0]    pwmS;
  logic          enS, skipS, lsLowS, swLowS, hsDisS;
  logic          dtDone, tmoDone;
  seqStrobe_t    strobe;

  assign rawIn = {pwmCmd, outEnN, skipN, lsGateLow, swNodeLow, hsDischarged};
  assign {pwmS, enS, skipS, lsLowS, swLowS, hsDisS} = syncIn;

  gseq_sync #(.W(SW), .RST_VAL(SYNC_RST)) i_sync (
    .clk(clk), .rstN(rstN), .din(rawIn), .dout(syncIn)
  );

  gseq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .pwmS(pwmS), .enS(enS), .lsLowS(lsLowS),
    .swLowS(swLowS), .dtDone(dtDone), .tmoDone(tmoDone), .strobe(strobe)
  );

  gseq_dp #(.DT_HI_CYC(DT_HI_CYC), .DT_LO_CYC(DT_LO_CYC), .TMO_CYC(TMO_CYC)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pwmS(pwmS), .enS(enS),
    .skipS(skipS), .hsDisS(hsDisS), .dtDone(dtDone), .tmoDone(tmoDone),
    .gateHi(gateHi), .gateLo(gateLo)
  );
endmodule

// File: rtl/gseq_checker.sv
module gseq_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] pwmCmd,
  input logic       outEnN,
  input logic       skipN,
  input logic       gateHi,
  input logic       gateLo
);
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(gateHi && gateLo));

  p_hi_needs_cmd_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pwmCmd, 3) != 2'b01) |-> !gateHi);

  p_lo_needs_cmd_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pwmCmd, 3) != 2'b00) |-> !gateLo);

  p_mid_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(pwmCmd, 3) == 2'b10 || $past(pwmCmd, 3) == 2'b11) |-> (!gateHi && !gateLo));

  p_disable_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(outEnN, 3) |-> (!gateHi && !gateLo));

  p_skip_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(skipN, 3) |-> !gateLo);

  p_hi_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateHi) |-> (!$past(gateLo, 1) && !$past(gateLo, 2)));

  p_lo_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateLo) |-> (!$past(gateHi, 1) && !$past(gateHi, 2)));
endmodule

bind gate_sequencer gseq_checker i_chk (
  .clk(clk), .rstN(rstN), .pwmCmd(pwmCmd), .outEnN(outEnN), .skipN(skipN),
  .gateHi(gateHi), .gateLo(gateLo)
);

// File: tb/test_gate_sequencer.sv
module test_gate_sequencer;
  localparam int DT_HI = 5;
  localparam int DT_LO = 4;
  localparam int TMO   = 50;
  localparam logic [1:0] C_LO = 2'b00, C_HI = 2'b01, C_MID = 2'b10;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] pwmCmd = C_MID;
  logic outEnN = 1'b1, skipN = 1'b1;
  logic lsGateLow = 1'b0, swNodeLow = 1'b0, hsDischarged = 1'b0;
  logic gateHi, gateLo;

  int total = 0, bad = 0, cycles = 0, overlaps = 0;
  bit finished = 0;

  gate_sequencer #(.DT_HI_CYC(DT_HI), .DT_LO_CYC(DT_LO), .TMO_CYC(TMO)) i_gate_sequencer (
    .clk(clk), .rstN(rstN), .pwmCmd(pwmCmd), .outEnN(outEnN), .skipN(skipN),
    .lsGateLow(lsGateLow), .swNodeLow(swNodeLow), .hsDischarged(hsDischarged),
    .gateHi(gateHi), .gateLo(gateLo)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rstN && gateHi && gateLo) overlaps++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  // counts edges until the selected output is high; returns 0 if never
  task automatic riseEdge(input bit hi, input int limit, output int at, output bit otherSeen);
    at = 0;
    otherSeen = 0;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk);
      #1;
      if (hi ? gateLo : gateHi) otherSeen = 1;
      if ((hi ? gateHi : gateLo) && at == 0) at = k;
      if (at != 0) break;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    edges(3);
    check(!gateHi && !gateLo, "R11 reset", {gateHi, gateLo}, 0);
    @(negedge clk) rstN = 1'b1;
    edges(12);
    check(!gateHi && !gateLo, "R11 mid after reset", {gateHi, gateLo}, 0);
  endtask

  task automatic lowViaSwitchNode();
    int at; bit other;
    @(negedge clk);
    lsGateLow = 1; swNodeLow = 1; hsDischarged = 0; pwmCmd = C_LO;
    riseEdge(0, 40, at, other);
    check(at == 5 + DT_LO, "R7 sensed low edge", at, 5 + DT_LO);
    check(!other, "R2 no high side during low", other, 0);
  endtask

  task automatic highViaGate();
    int at; bit other;
    @(negedge clk);
    lsGateLow = 1; pwmCmd = C_HI;
    edges(3);
    check(!gateLo, "R1 low side off for high cmd", gateLo, 0);
    @(negedge clk);
    riseEdge(1, 40, at, other);
    // 3 edges already passed above
    check(at + 3 == 5 + DT_HI, "R6 sensed high edge", at + 3, 5 + DT_HI);
    check(gateHi && !gateLo, "R1 high side on", gateHi, 1);
  endtask

  task automatic lowViaTimeout();
    int at; bit other;
    @(negedge clk);
    swNodeLow = 0; hsDischarged = 1; pwmCmd = C_LO;
    riseEdge(0, 80, at, other);
    check(at == 4 + TMO, "R8 timeout low edge", at, 4 + TMO);
  endtask

  task automatic stuckThenReverse();
    int at; bit other;
    @(negedge clk);
    lsGateLow = 0; hsDischarged = 0; swNodeLow = 1; pwmCmd = C_HI;
    riseEdge(1, 30, at, other);
    check(at == 0, "R6 waits for low-side flag", at, 0);
    @(negedge clk) pwmCmd = C_LO;
    riseEdge(0, 40, at, other);
    check(at == 5 + DT_LO, "R10 reversal restarts low", at, 5 + DT_LO);
    check(!other, "R10 no high side after reversal", other, 0);
  endtask

  task automatic skipMode();
    int at; bit other;
    @(negedge clk) skipN = 0;
    edges(3);
    check(!gateLo, "R5 skip forces low side off", gateLo, 0);
    @(negedge clk) begin lsGateLow = 1; pwmCmd = C_HI; end
    riseEdge(1, 40, at, other);
    check(at == 5 + DT_HI, "R5 high side follows in skip", at, 5 + DT_HI);
    @(negedge clk) pwmCmd = C_LO;
    riseEdge(0, 20, at, other);
    check(at == 0, "R5 low side held in skip", at, 0);
    @(negedge clk) skipN = 1;
    edges(3);
    check(gateLo, "R5 low side resumes", gateLo, 1);
  endtask

  task automatic disableMode();
    int at; bit other;
    @(negedge clk) outEnN = 0;
    edges(3);
    check(!gateLo && !gateHi, "R4 disable off", {gateHi, gateLo}, 0);
    @(negedge clk) pwmCmd = C_HI;
    edges(20);
    check(!gateLo && !gateHi, "R4 stays off when disabled", {gateHi, gateLo}, 0);
    @(negedge clk) outEnN = 1;
    riseEdge(1, 40, at, other);
    check(at == 5 + DT_HI, "R4 restart after enable", at, 5 + DT_HI);
  endtask

  task automatic midLevel();
    @(negedge clk) pwmCmd = C_MID;
    edges(3);
    check(!gateLo && !gateHi, "R3 mid shutoff", {gateHi, gateLo}, 0);
    edges(10);
    check(!gateLo && !gateHi, "R3 mid stays off", {gateHi, gateLo}, 0);
  endtask

  initial begin
    doReset();
    lowViaSwitchNode();
    highViaGate();
    lowViaTimeout();
    stuckThenReverse();
    skipMode();
    disableMode();
    midLevel();
    check(overlaps == 0, "R9 no overlap", overlaps, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule